// File: doc/BRIEF.md
# Board Control Register Bank

This block is a 4 KB window of 32-bit control and identity words that sits on a simple single-cycle bus. The bus gives a select, a write flag, a byte address and write data. Read data is registered and appears on the cycle after the read. Software uses the bank for several jobs:

- set a memory remap line;
- light a row of LEDs;
- keep a few board-specific configuration words;
- read identity values that are fixed when the chip is built;
- pick which clock-generator lock signals count towards a combined "all locked" flag.

The presence of some words depends on a part number taken from the bank's own identity word. Each build therefore exposes only the words its variant defines. Four word slots near the middle of the window belong to a separate configuration-transaction engine. This bank only forwards them: it gives that engine a request strobe, a slot index and a write flag, and it returns the engine's read data.

Any access to an offset that is absent or unmapped reads as zero and changes nothing. Such an access also raises a one-cycle error flag.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, the following values hold:
  - word 0 reads as the `CFG0_RST` parameter;
  - words 1, 2, 5 and 6 read zero;
  - the lock-mask field is all ones;
  - `remap_o` equals bit 0 of `CFG0_RST`;
  - `led_o` is zero;
  - `bus_rdata` and `bus_err` are zero.
- R2: Words 0 (byte 0x000) and 1 (byte 0x004) are read/write. `remap_o` follows bit 0 of word 0, and `led_o[i]` follows bit i of word 1, from the cycle after the write.
- R3: Word 3 (0x00C) always reads zero. Word 4 (0x010), the auxiliary identity (0xFF8) and the main identity (0xFFC) return their parameter values. Writes to these four words change nothing and raise no error.
- R4: The part number is bits [11:4] of the main identity. Words 2 (0x008) and 5 (0x014) exist when the part number equals `PART_FULL` or `PART_LITE`. Word 6 (0x018) exists only for `PART_FULL`. A word that exists is read/write.
- R5: An access to an absent word, or to any offset not listed in R2, R3, R4, R6 or R7, has these effects:
  - a read returns zero;
  - a write changes no state;
  - `bus_err` is high for exactly the cycle after each such access.
- R6: The lock word at 0x100 has the following fields:
  - bits [31:24] are the writable lock mask;
  - bits [23:16] mirror `dll_lock`;
  - bits [15:1] read zero;
  - bit 0 is 1 exactly when every `dll_lock` bit whose mask bit is 1 is high.

  Writes touch only the mask.
- R7: An access to 0x0A0 to 0x0AC drives `xact_req` high in the same cycle, with `xact_idx` set to address bits [3:2] and `xact_wr` set to `bus_wr`. A read there returns `xact_rdata`, and the access raises no error.
- R8: Address bits [1:0] are ignored.
- R9: `bus_rdata` updates only on the cycle after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Pulse after an absent or unmapped access |
| remap_o | output | 1 | Remap control (word 0 bit 0) |
| led_o | output | N_LED | LED drive (word 1 low bits) |
| dll_lock | input | 8 | Per-generator lock status |
| xact_req | output | 1 | Access to the transaction-engine slots |
| xact_wr | output | 1 | Write flag for the transaction engine |
| xact_idx | output | 2 | Transaction slot index |
| xact_rdata | input | 32 | Read data from the transaction engine |

## Verification
The hardest case to reach from the ports is register presence. Presence is fixed by a parameter, so one build can never show a word being both present and absent. The bench therefore runs three copies side by side from the same stimulus: one with the full part number, one with the lite part number, and one matching neither. A single write to word 6 thus lands in one copy and raises an error in the other two.

The combined lock bit needs mask and lock patterns in which exactly one selected input is low. The bench mixes directed patterns of this kind with random ones.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DLL_N = 8;

  localparam logic [9:0] IDX_CFG0   = 10'h000;
  localparam logic [9:0] IDX_CFG1   = 10'h001;
  localparam logic [9:0] IDX_CFG2   = 10'h002;
  localparam logic [9:0] IDX_CFG3   = 10'h003;
  localparam logic [9:0] IDX_CFG4   = 10'h004;
  localparam logic [9:0] IDX_CFG5   = 10'h005;
  localparam logic [9:0] IDX_CFG6   = 10'h006;
  localparam logic [9:0] IDX_XACT0  = 10'h028;
  localparam logic [9:0] IDX_XACT1  = 10'h029;
  localparam logic [9:0] IDX_XACT2  = 10'h02A;
  localparam logic [9:0] IDX_XACT3  = 10'h02B;
  localparam logic [9:0] IDX_DLL    = 10'h040;
  localparam logic [9:0] IDX_AID    = 10'h3FE;
  localparam logic [9:0] IDX_ID     = 10'h3FF;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CFG0,
    SEL_CFG1,
    SEL_CFG2,
    SEL_CFG3,
    SEL_CFG4,
    SEL_CFG5,
    SEL_CFG6,
    SEL_XACT,
    SEL_DLL,
    SEL_AID,
    SEL_ID
  } reg_sel_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter bit HAS_W25 = 1'b1,
  parameter bit HAS_W6  = 1'b1
) (
  input  logic [11:0] addr,
  output reg_sel_e    sel
);

  logic [9:0] widx;
  assign widx = 10'(addr >> 2);

  always_comb begin
    sel = SEL_NONE;
    case (widx)
      IDX_CFG0:  sel = SEL_CFG0;
      IDX_CFG1:  sel = SEL_CFG1;
      IDX_CFG2:  if (HAS_W25) sel = SEL_CFG2;
      IDX_CFG3:  sel = SEL_CFG3;
      IDX_CFG4:  sel = SEL_CFG4;
      IDX_CFG5:  if (HAS_W25) sel = SEL_CFG5;
      IDX_CFG6:  if (HAS_W6)  sel = SEL_CFG6;
      IDX_XACT0, IDX_XACT1,
      IDX_XACT2, IDX_XACT3: sel = SEL_XACT;
      IDX_DLL:   sel = SEL_DLL;
      IDX_AID:   sel = SEL_AID;
      IDX_ID:    sel = SEL_ID;
      default:   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sysctl_cfgword.sv
module sysctl_cfgword #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_d;
  end

endmodule

// File: rtl/sysctl_dll.sv
module sysctl_dll
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DLL_N-1:0] wmask,
  input  logic [DLL_N-1:0] lock,
  output logic [31:0]      value
);

  logic [DLL_N-1:0] mask_q;
  logic [DLL_N-1:0] mask_d;
  logic [DLL_N-1:0] ok_bit;
  logic             all_ok;

  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < DLL_N; i++) begin : g_ok
    assign ok_bit[i] = lock[i] | ~mask_q[i];
  end

  assign all_ok = &ok_bit;
  assign value  = {mask_q, lock, 15'd0, all_ok};

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          N_LED     = 8,
  parameter logic [31:0] ID_VAL    = 32'h4104_0520,
  parameter logic [31:0] AID_VAL   = 32'h0200_0008,
  parameter logic [31:0] CFG4_VAL  = 32'h0000_0003,
  parameter logic [31:0] CFG0_RST  = 32'h0000_0001,
  parameter logic [7:0]  PART_FULL = 8'h52,
  parameter logic [7:0]  PART_LITE = 8'h54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  output logic             remap_o,
  output logic [N_LED-1:0] led_o,
  input  logic [7:0]       dll_lock,
  output logic             xact_req,
  output logic             xact_wr,
  output logic [1:0]       xact_idx,
  input  logic [31:0]      xact_rdata
);

  localparam logic [7:0] PART    = ID_VAL[11:4];
  localparam bit         HAS_W25 = (PART == PART_FULL) || (PART == PART_LITE);
  localparam bit         HAS_W6  = (PART == PART_FULL);

  reg_sel_e    sel;
  logic        wr_hit;
  logic        rd_hit;
  logic [31:0] cfg0_q, cfg1_q, cfg2_q, cfg5_q, cfg6_q;
  logic [31:0] dll_val;
  logic [31:0] rd_mux;
  logic [31:0] rdata_d;
  logic        err_d;

  sysctl_decode #(.HAS_W25(HAS_W25), .HAS_W6(HAS_W6)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  sysctl_cfgword #(.W(32), .RST(CFG0_RST)) u_w0 (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && (sel == SEL_CFG0)),
    .d(bus_wdata), .q(cfg0_q)
  );

  sysctl_cfgword #(.W(32), .RST(32'd0)) u_w1 (
    .clk(clk), .rst_n(rst_n), .we(wr_hit && (sel == SEL_CFG1)),
    .d(bus_wdata), .q(cfg1_q)
  );

  if (HAS_W25) begin : g_w25
    sysctl_cfgword #(.W(32), .RST(32'd0)) u_w2 (
      .clk(clk), .rst_n(rst_n), .we(wr_hit && (sel == SEL_CFG2)),
      .d(bus_wdata), .q(cfg2_q)
    );
    sysctl_cfgword #(.W(32), .RST(32'd0)) u_w5 (
      .clk(clk), .rst_n(rst_n), .we(wr_hit && (sel == SEL_CFG5)),
      .d(bus_wdata), .q(cfg5_q)
    );
  end else begin : g_no_w25
    assign cfg2_q = '0;
    assign cfg5_q = '0;
  end

  if (HAS_W6) begin : g_w6
    sysctl_cfgword #(.W(32), .RST(32'd0)) u_w6 (
      .clk(clk), .rst_n(rst_n), .we(wr_hit && (sel == SEL_CFG6)),
      .d(bus_wdata), .q(cfg6_q)
    );
  end else begin : g_no_w6
    assign cfg6_q = '0;
  end

  sysctl_dll u_dll (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_hit && (sel == SEL_DLL)),
    .wmask (bus_wdata[31:24]),
    .lock  (dll_lock),
    .value (dll_val)
  );

  always_comb begin
    case (sel)
      SEL_CFG0: rd_mux = cfg0_q;
      SEL_CFG1: rd_mux = cfg1_q;
      SEL_CFG2: rd_mux = cfg2_q;
      SEL_CFG3: rd_mux = '0;
      SEL_CFG4: rd_mux = CFG4_VAL;
      SEL_CFG5: rd_mux = cfg5_q;
      SEL_CFG6: rd_mux = cfg6_q;
      SEL_XACT: rd_mux = xact_rdata;
      SEL_DLL:  rd_mux = dll_val;
      SEL_AID:  rd_mux = AID_VAL;
      SEL_ID:   rd_mux = ID_VAL;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = bus_rdata;
    if (rd_hit) rdata_d = rd_mux;
    err_d = bus_sel && (sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  assign remap_o  = cfg0_q[0];
  assign led_o    = cfg1_q[N_LED-1:0];
  assign xact_req = bus_sel && (sel == SEL_XACT);
  assign xact_wr  = bus_wr;
  assign xact_idx = bus_addr[3:2];

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int N_LED = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic             remap_o,
  input logic [N_LED-1:0] led_o,
  input logic [7:0]       dll_lock,
  input logic             xact_req
);

  a_r2_remap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[11:2] == 10'h000) |=> (remap_o == $past(bus_wdata[0])));

  a_r2_led_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[11:2] == 10'h001) |=> (led_o == $past(bus_wdata[N_LED-1:0])));

  a_r3_word3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[11:2] == 10'h003) |=> (bus_rdata == 32'd0));

  a_r6_lock_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[11:2] == 10'h040)
      |=> (bus_rdata[23:16] == $past(dll_lock) && bus_rdata[15:1] == 15'd0));

  a_r7_xact_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    xact_req |=> !bus_err);

  a_r5_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !$past(bus_wr)) |-> (bus_rdata == 32'd0));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(.N_LED(N_LED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .remap_o   (remap_o),
  .led_o     (led_o),
  .dll_lock  (dll_lock),
  .xact_req  (xact_req)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int N_LED = 8;
  localparam logic [31:0] AID_V  = 32'h0200_0008;
  localparam logic [31:0] CFG4_V = 32'h0000_0003;
  localparam logic [31:0] CFG0_R = 32'h0000_0001;
  localparam logic [31:0] ID_F   = 32'h4104_0520;
  localparam logic [31:0] ID_L   = 32'h4104_0540;
  localparam logic [31:0] ID_N   = 32'h4104_0500;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [7:0]  dll_lock;
  logic [31:0] xrd;

  logic [31:0]      rd [NI];
  logic             er [NI];
  logic             rm [NI];
  logic [N_LED-1:0] ld [NI];
  logic             xq [NI];
  logic             xw [NI];
  logic [1:0]       xi [NI];

  sysctl_regbank #(.N_LED(N_LED), .ID_VAL(ID_F), .AID_VAL(AID_V), .CFG4_VAL(CFG4_V),
    .CFG0_RST(CFG0_R)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd[0]), .bus_err(er[0]), .remap_o(rm[0]), .led_o(ld[0]),
    .dll_lock(dll_lock), .xact_req(xq[0]), .xact_wr(xw[0]), .xact_idx(xi[0]), .xact_rdata(xrd));

  sysctl_regbank #(.N_LED(N_LED), .ID_VAL(ID_L), .AID_VAL(AID_V), .CFG4_VAL(CFG4_V),
    .CFG0_RST(CFG0_R)) dut_l (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd[1]), .bus_err(er[1]), .remap_o(rm[1]), .led_o(ld[1]),
    .dll_lock(dll_lock), .xact_req(xq[1]), .xact_wr(xw[1]), .xact_idx(xi[1]), .xact_rdata(xrd));

  sysctl_regbank #(.N_LED(N_LED), .ID_VAL(ID_N), .AID_VAL(AID_V), .CFG4_VAL(CFG4_V),
    .CFG0_RST(CFG0_R)) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd[2]), .bus_err(er[2]), .remap_o(rm[2]), .led_o(ld[2]),
    .dll_lock(dll_lock), .xact_req(xq[2]), .xact_wr(xw[2]), .xact_idx(xi[2]), .xact_rdata(xrd));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model
  logic [31:0] m_cfg0 [NI], m_cfg1 [NI], m_cfg2 [NI], m_cfg5 [NI], m_cfg6 [NI];
  logic [7:0]  m_mask [NI];
  logic [31:0] e_rd [NI];
  logic        e_err [NI];
  string       e_tag [NI];

  function automatic bit has25(int k); return k != 2; endfunction
  function automatic bit has6(int k);  return k == 0; endfunction

  function automatic logic [31:0] id_of(int k);
    return (k == 0) ? ID_F : (k == 1) ? ID_L : ID_N;
  endfunction

  function automatic bit is_xact(logic [11:0] a);
    return (a[11:2] >= 10'h028) && (a[11:2] <= 10'h02B);
  endfunction

  function automatic bit mapped(int k, logic [11:0] a);
    case (a[11:2])
      10'h000, 10'h001, 10'h003, 10'h004, 10'h040, 10'h3FE, 10'h3FF: return 1'b1;
      10'h002, 10'h005: return has25(k);
      10'h006: return has6(k);
      default: return is_xact(a);
    endcase
  endfunction

  function automatic logic [31:0] m_read(int k, logic [11:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (m_mask[k][i] && !dll_lock[i]) ok = 1'b0;
    if (is_xact(a)) return xrd;
    case (a[11:2])
      10'h000: return m_cfg0[k];
      10'h001: return m_cfg1[k];
      10'h002: return has25(k) ? m_cfg2[k] : 32'd0;
      10'h004: return CFG4_V;
      10'h005: return has25(k) ? m_cfg5[k] : 32'd0;
      10'h006: return has6(k) ? m_cfg6[k] : 32'd0;
      10'h040: return {m_mask[k], dll_lock, 15'd0, ok};
      10'h3FE: return AID_V;
      10'h3FF: return id_of(k);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < NI; k++) begin
      if (!rst_n) begin
        m_cfg0[k] = CFG0_R; m_cfg1[k] = 0; m_cfg2[k] = 0; m_cfg5[k] = 0; m_cfg6[k] = 0;
        m_mask[k] = 8'hFF; e_rd[k] = 0; e_err[k] = 0; e_tag[k] = "R1";
      end else begin
        e_err[k] = bus_sel && !mapped(k, bus_addr);
        if (bus_sel && !bus_wr) begin
          e_rd[k]  = m_read(k, bus_addr);
          e_tag[k] = cur_tag;
        end
        if (bus_sel && bus_wr) begin
          case (bus_addr[11:2])
            10'h000: m_cfg0[k] = bus_wdata;
            10'h001: m_cfg1[k] = bus_wdata;
            10'h002: if (has25(k)) m_cfg2[k] = bus_wdata;
            10'h005: if (has25(k)) m_cfg5[k] = bus_wdata;
            10'h006: if (has6(k))  m_cfg6[k] = bus_wdata;
            10'h040: m_mask[k] = bus_wdata[31:24];
            default: ;
          endcase
        end
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int k = 0; k < NI; k++) begin
        chk(e_tag[k], $sformatf("rdata[%0d]", k), rd[k], e_rd[k]);
        chk("R5", $sformatf("err[%0d]", k), {31'd0, er[k]}, {31'd0, e_err[k]});
        chk("R2", $sformatf("remap[%0d]", k), {31'd0, rm[k]}, {31'd0, m_cfg0[k][0]});
        chk("R2", $sformatf("led[%0d]", k), {24'd0, ld[k]}, {24'd0, m_cfg1[k][N_LED-1:0]});
      end
    end
  end

  task automatic access(input logic [11:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    for (int k = 0; k < NI; k++) begin
      chk("R7", $sformatf("xact_req[%0d]", k), {31'd0, xq[k]}, {31'd0, is_xact(a)});
      if (is_xact(a)) begin
        chk("R7", $sformatf("xact_idx[%0d]", k), {30'd0, xi[k]}, {30'd0, a[3:2]});
        chk("R7", $sformatf("xact_wr[%0d]", k), {31'd0, xw[k]}, {31'd0, w});
      end
    end
    @(posedge clk);
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [11:0] alist [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                              12'h018, 12'h01C, 12'h0A0, 12'h0A4, 12'h0AC, 12'h100,
                              12'h104, 12'h800, 12'hFF8, 12'hFFC};

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    dll_lock = 8'hFF; xrd = 32'hC0DE_5A5A;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      chk("R1", "reset remap", {31'd0, rm[k]}, {31'd0, CFG0_R[0]});
      chk("R1", "reset led", {24'd0, ld[k]}, 32'd0);
      chk("R1", "reset rdata", rd[k], 32'd0);
      chk("R1", "reset err", {31'd0, er[k]}, 32'd0);
    end
    rst_n = 1'b1;
    cmp_on = 1;
    cur_tag = "R1";
    foreach (alist[i]) access(alist[i], 1'b0, 0);

    cur_tag = "R2";
    access(12'h000, 1, 32'hDEAD_BEE0); access(12'h000, 0, 0);
    access(12'h004, 1, 32'h1234_56A5); access(12'h004, 0, 0);
    access(12'h000, 1, 32'h0000_0003); access(12'h000, 0, 0);

    cur_tag = "R4";
    access(12'h008, 1, 32'h1111_2222); access(12'h014, 1, 32'h3333_4444);
    access(12'h018, 1, 32'h5555_6666);
    access(12'h008, 0, 0); access(12'h014, 0, 0); access(12'h018, 0, 0);

    cur_tag = "R3";
    access(12'h00C, 1, 32'hFFFF_FFFF); access(12'h010, 1, 32'hFFFF_FFFF);
    access(12'hFF8, 1, 32'hFFFF_FFFF); access(12'hFFC, 1, 32'hFFFF_FFFF);
    access(12'h00C, 0, 0); access(12'h010, 0, 0); access(12'hFF8, 0, 0); access(12'hFFC, 0, 0);

    cur_tag = "R5";
    access(12'h01C, 1, 32'hAAAA_AAAA); access(12'h01C, 0, 0);
    access(12'h104, 0, 0); access(12'h0FC, 1, 1); access(12'hFF4, 0, 0);
    access(12'h018, 0, 0); access(12'h004, 0, 0);

    cur_tag = "R6";
    access(12'h100, 1, 32'h0F00_FFFF); access(12'h100, 0, 0);
    @(negedge clk); dll_lock = 8'hF7; access(12'h100, 0, 0);
    @(negedge clk); dll_lock = 8'hEF; access(12'h100, 0, 0);
    access(12'h100, 1, 32'hFF00_0000); access(12'h100, 0, 0);
    access(12'h100, 1, 32'h0000_0000); access(12'h100, 0, 0);
    @(negedge clk); dll_lock = 8'hFF;

    cur_tag = "R7";
    xrd = 32'h0BAD_F00D;
    access(12'h0A0, 0, 0); access(12'h0A4, 1, 32'h77); access(12'h0A8, 0, 0); access(12'h0AC, 0, 0);

    cur_tag = "R8";
    access(12'h007, 1, 32'h0000_00F0); access(12'h005, 0, 0);
    access(12'hFFF, 0, 0); access(12'h0A6, 0, 0); access(12'h101, 0, 0);

    cur_tag = "R9";
    access(12'hFFC, 0, 0); idle(4); access(12'h000, 1, 32'h0); idle(2);

    cur_tag = "R4";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      dll_lock = 8'($urandom);
      xrd = $urandom;
      access(alist[$urandom % 16] | 12'($urandom % 4), 1'($urandom), $urandom);
    end
    idle(3);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule